// File: doc/BRIEF.md
# DMA Interrupt and Bus-Error Status Register

This block holds the status word of an Ethernet MAC's DMA engine. Three event levels come in from the MAC's sub-blocks: a timestamp unit, a power-management unit and a statistics-counter unit. Each level is mirrored into its own summary bit of the status word. The summary bits track their sources and nothing else. A register write cannot clear them. The only way software lowers one is to clear the cause inside the sub-block that raised it.

A registered interrupt line is high whenever a source level is high and its enable bit is set. The same word also holds a fatal bus-error flag and a 3-bit field that records the kind of access that received the error response. A one-cycle error pulse captures both. Writing a 1 to the flag clears the flag and the field together. The flag and the field never drive the interrupt line.

Top module: `dma_status_agg`

## Requirements
- R1: Status bit 29 follows the timestamp level, bit 28 the power-management level and bit 27 the statistics level, each one clock edge after the input.
- R2: A register write, whatever its data, never changes bits 29:27.
- R3: `irq_o` is registered and equals the OR over sources of (level AND enable), one clock edge after the inputs. `irq_en_i` bit 0 enables the statistics source, bit 1 the power-management source and bit 2 the timestamp source.
- R4: A `bus_err_i` pulse sets bit 13 on the same clock edge that it loads bits 25:23. Bit 23 takes `err_tx_i` (1 = transmit DMA, 0 = receive DMA). Bit 24 takes `err_rd_i` (1 = read, 0 = write). Bit 25 takes `err_desc_i` (1 = descriptor access, 0 = data buffer).
- R5: Bits 25:23 read 0 whenever bit 13 is 0. A write with data bit 13 = 1 clears bit 13 and bits 25:23. A write with data bit 13 = 0 leaves them unchanged.
- R6: When an error pulse and a clearing write arrive in the same cycle, the pulse wins: bit 13 ends up 1 and the field holds the new attributes.
- R7: Bit 13 and bits 25:23 never affect `irq_o`.
- R8: Bits 31:30, bit 26 and every bit outside 29:27, 25:23 and 13 read 0.
- R9: Asserting `rst_n` low clears the status word and `irq_o` at once, without waiting for a clock edge.
- R10: An error pulse that arrives while bit 13 is already set replaces the field with the attributes of the newer error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ts_evt_i | input | 1 | Timestamp-unit event level |
| pm_evt_i | input | 1 | Power-management event level |
| cnt_evt_i | input | 1 | Statistics-counter event level |
| irq_en_i | input | 3 | Interrupt enables {ts, pm, cnt} |
| bus_err_i | input | 1 | One-cycle fatal bus-error pulse |
| err_tx_i | input | 1 | Error came from transmit DMA (1) or receive DMA (0) |
| err_rd_i | input | 1 | Error was on a read (1) or a write (0) |
| err_desc_i | input | 1 | Error was on a descriptor (1) or a data buffer (0) |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 32 | Status register write data |
| stat_o | output | 32 | Packed status word |
| irq_o | output | 1 | Registered interrupt |

## Verification
The bench writes all ones to the word while every source is high. A design that treats the summary bits as write-1-to-clear drops them here, and that shows up in the next sampled word. It sends an error pulse in the same cycle as a clearing write, which catches a design that gives the clear priority and loses the error. It also sends a second pulse with different attributes while the flag is still set, which catches a design that keeps the stale field. Sweeps over the enables, with errors present, check two things. A design that ORs the error flag into the interrupt fires on an error alone. A design that ignores enable positions fires on the wrong source. A clear followed by a read of the field catches a design that leaves old attributes behind the flag.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int STAT_W    = 32;
  localparam int NSRC      = 3;
  localparam int SRC_LSB   = 27;
  localparam int ATTR_W    = 3;
  localparam int ATTR_LSB  = 23;
  localparam int FATAL_BIT = 13;
  localparam int SRC_MSB   = SRC_LSB + NSRC - 1;
  localparam int ATTR_MSB  = ATTR_LSB + ATTR_W - 1;
  localparam logic [STAT_W-1:0] W1C_MASK = STAT_W'(1) << FATAL_BIT;

  typedef struct packed {
    logic desc;
    logic rd;
    logic tx;
  } err_attr_t;
endpackage

// File: rtl/stat_src_mirror.sv
module stat_src_mirror
  import dma_stat_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic lvl_d, lvl_q;

    always_comb begin
      lvl_d = lvl_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_d;
    end

    assign lvl_o[g] = lvl_q;
  end
endmodule

// File: rtl/stat_err_capture.sv
module stat_err_capture
  import dma_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      err_pulse_i,
  input  err_attr_t attr_i,
  input  logic      clr_i,
  output logic      fatal_o,
  output err_attr_t attr_o
);
  logic      fatal_d, fatal_q, upd;
  err_attr_t attr_d, attr_q;

  always_comb begin
    fatal_d = fatal_q;
    attr_d  = attr_q;
    upd     = 1'b0;
    if (err_pulse_i) begin
      fatal_d = 1'b1;
      attr_d  = attr_i;
      upd     = 1'b1;
    end else if (clr_i) begin
      fatal_d = 1'b0;
      attr_d  = '0;
      upd     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fatal_q <= 1'b0;
      attr_q  <= '0;
    end else if (upd) begin
      fatal_q <= fatal_d;
      attr_q  <= attr_d;
    end
  end

  assign fatal_o = fatal_q;
  assign attr_o  = attr_q;
endmodule

// File: rtl/stat_irq_gen.sv
module stat_irq_gen
  import dma_stat_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_d, irq_q;

  always_comb begin
    irq_d = |(lvl_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dma_status_agg.sv
module dma_status_agg
  import dma_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_evt_i,
  input  logic              pm_evt_i,
  input  logic              cnt_evt_i,
  input  logic [NSRC-1:0]   irq_en_i,
  input  logic              bus_err_i,
  input  logic              err_tx_i,
  input  logic              err_rd_i,
  input  logic              err_desc_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic [NSRC-1:0] src_lvl, src_q;
  logic            fatal_q, clr;
  err_attr_t       attr_in, attr_q;

  assign src_lvl = {ts_evt_i, pm_evt_i, cnt_evt_i};
  assign attr_in = '{desc: err_desc_i, rd: err_rd_i, tx: err_tx_i};
  assign clr     = wr_en_i && ((wr_data_i & W1C_MASK) != '0);

  stat_src_mirror #(.N(NSRC)) u_mirror (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (src_lvl),
    .lvl_o (src_q)
  );

  stat_err_capture u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_pulse_i (bus_err_i),
    .attr_i      (attr_in),
    .clr_i       (clr),
    .fatal_o     (fatal_q),
    .attr_o      (attr_q)
  );

  stat_irq_gen #(.N(NSRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (src_lvl),
    .en_i  (irq_en_i),
    .irq_o (irq_o)
  );

  always_comb begin
    stat_o                     = '0;
    stat_o[SRC_MSB:SRC_LSB]    = src_q;
    stat_o[ATTR_MSB:ATTR_LSB]  = attr_q;
    stat_o[FATAL_BIT]          = fatal_q;
  end
endmodule

// File: rtl/dma_status_agg_chk.sv
module dma_status_agg_chk
  import dma_stat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ts_evt_i,
  input logic              pm_evt_i,
  input logic              cnt_evt_i,
  input logic [NSRC-1:0]   irq_en_i,
  input logic              bus_err_i,
  input logic              wr_en_i,
  input logic [STAT_W-1:0] wr_data_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              irq_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: summary bits mirror the levels one edge later
  a_r1_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> stat_o[29:27] == $past({ts_evt_i, pm_evt_i, cnt_evt_i}));

  // R3 and R7: interrupt depends on enabled levels only
  a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> irq_o == $past(|({ts_evt_i, pm_evt_i, cnt_evt_i} & irq_en_i)));

  // R4: pulse sets the flag
  a_r4_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_i |=> stat_o[13]);

  // R5: clearing write without a pulse lowers the flag
  a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[13] && !bus_err_i) |=> !stat_o[13]);

  // R5: field is zero while the flag is clear
  a_r5_attr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_o[13] |-> stat_o[25:23] == 3'b000);

  // R8: reserved and out-of-scope bits are zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o[31:30] == 2'b00) && !stat_o[26] &&
    (stat_o[22:14] == '0) && (stat_o[12:0] == '0));
endmodule

bind dma_status_agg dma_status_agg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ts_evt_i  (ts_evt_i),
  .pm_evt_i  (pm_evt_i),
  .cnt_evt_i (cnt_evt_i),
  .irq_en_i  (irq_en_i),
  .bus_err_i (bus_err_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .stat_o    (stat_o),
  .irq_o     (irq_o)
);

// File: tb/sim_dma_status_agg.sv
module sim_dma_status_agg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ts, pm, cnt;
  logic [2:0]  en;
  logic        berr, etx, erd, edesc;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] stat;
  logic        irq;

  int errors = 0;
  int checks = 0;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  // independent model state
  logic [2:0] m_src;
  logic       m_fatal;
  logic [2:0] m_attr;
  logic       m_irq;

  always #10 clk = ~clk;

  dma_status_agg u0 (
    .clk(clk), .rst_n(rst_n),
    .ts_evt_i(ts), .pm_evt_i(pm), .cnt_evt_i(cnt),
    .irq_en_i(en),
    .bus_err_i(berr), .err_tx_i(etx), .err_rd_i(erd), .err_desc_i(edesc),
    .wr_en_i(wr), .wr_data_i(wdata),
    .stat_o(stat), .irq_o(irq)
  );

  function automatic logic [31:0] pack_word();
    logic [31:0] w = '0;
    w[29:27] = m_src;
    w[25:23] = m_attr;
    w[13]    = m_fatal;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(input string tag,
                      input logic [2:0] src, input logic [2:0] ie,
                      input logic be, input logic [2:0] attr,
                      input logic we, input logic [31:0] wd);
    @(negedge clk);
    {ts, pm, cnt} = src;
    en = ie;
    berr = be;
    {edesc, erd, etx} = attr;
    wr = we;
    wdata = wd;
    m_src = src;
    m_irq = |(src & ie);
    if (be) begin
      m_fatal = 1'b1;
      m_attr  = attr;
    end else if (we && wd[13]) begin
      m_fatal = 1'b0;
      m_attr  = 3'b000;
    end
    exp_q.push_back({m_irq, pack_word()});
    tag_q.push_back(tag);
  endtask

  // monitor: compare results well after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && exp_q.size() > 0) begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " word"}, stat, e[31:0]);
        check({t, " irq"}, {31'b0, irq}, {31'b0, e[32]});
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ts, pm, cnt} = 3'b000; en = 3'b000;
    berr = 1'b0; {edesc, erd, etx} = 3'b000;
    wr = 1'b0; wdata = '0;
    m_src = '0; m_fatal = 1'b0; m_attr = '0; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R9 reset word", stat, 32'h0);
    check("R9 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: each source alone and together, enables off
    step("R1 ts",  3'b100, 3'b000, 0, 3'b000, 0, 32'h0);
    step("R1 pm",  3'b010, 3'b000, 0, 3'b000, 0, 32'h0);
    step("R1 cnt", 3'b001, 3'b000, 0, 3'b000, 0, 32'h0);
    step("R1 all", 3'b111, 3'b000, 0, 3'b000, 0, 32'h0);
    // R2: writes of all ones do not clear summary bits
    step("R2 wr ones", 3'b111, 3'b000, 0, 3'b000, 1, 32'hFFFF_FFFF);
    step("R2 hold",    3'b111, 3'b000, 0, 3'b000, 1, 32'h3800_0000);
    step("R1 drop",    3'b000, 3'b000, 0, 3'b000, 0, 32'h0);
    // R3: enable positions
    step("R3 cnt en",   3'b001, 3'b001, 0, 3'b000, 0, 32'h0);
    step("R3 cnt mask", 3'b001, 3'b110, 0, 3'b000, 0, 32'h0);
    step("R3 pm en",    3'b010, 3'b010, 0, 3'b000, 0, 32'h0);
    step("R3 ts en",    3'b100, 3'b100, 0, 3'b000, 0, 32'h0);
    step("R3 ts mask",  3'b100, 3'b011, 0, 3'b000, 0, 32'h0);
    step("R3 off",      3'b000, 3'b111, 0, 3'b000, 0, 32'h0);
    // R4: error capture with distinct attributes
    step("R4 err tx",   3'b000, 3'b111, 1, 3'b001, 0, 32'h0);
    step("R7 no irq",   3'b000, 3'b111, 0, 3'b110, 0, 32'h0);
    step("R5 wr0 keep", 3'b000, 3'b111, 0, 3'b000, 1, 32'hFFFF_DFFF);
    // R10: newer error replaces field
    step("R10 new err", 3'b000, 3'b000, 1, 3'b110, 0, 32'h0);
    step("R10 hold",    3'b010, 3'b000, 0, 3'b000, 0, 32'h0);
    // R5: clearing write zeroes flag and field
    step("R5 clear",    3'b000, 3'b000, 0, 3'b111, 1, 32'h0000_2000);
    step("R5 after",    3'b000, 3'b000, 0, 3'b111, 0, 32'h0);
    // R6: pulse and clear in the same cycle
    step("R6 err set",  3'b000, 3'b000, 1, 3'b010, 0, 32'h0);
    step("R6 collide",  3'b000, 3'b000, 1, 3'b101, 1, 32'h0000_2000);
    step("R6 after",    3'b101, 3'b101, 0, 3'b000, 0, 32'h0);
    // R8: write ones everywhere leaves unused bits at zero
    step("R8 wr ones",  3'b101, 3'b000, 0, 3'b000, 1, 32'hFFFF_DFFF);
    step("R7 err only", 3'b000, 3'b000, 1, 3'b111, 0, 32'h0);
    step("R8 idle",     3'b000, 3'b111, 0, 3'b000, 0, 32'h0);
    @(posedge clk);
    #5;
    @(posedge clk);
    #5;
    // R9: asynchronous reset clears mid-cycle
    @(negedge clk);
    {ts, pm, cnt} = 3'b111; en = 3'b111; berr = 1'b0; wr = 1'b0;
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check("R9 async word", stat, 32'h0);
    check("R9 async irq", {31'b0, irq}, 32'h0);
    if (exp_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R1 queue: actual=%0d expected=0", exp_q.size());
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule